// File: doc/BRIEF.md
# Sampling Tap Tuning Engine

This block searches for the best receive sampling delay of a high-speed SD or eMMC data path. After a start pulse in a tuning speed mode, it walks a 6-bit delay tap upward from zero through a fixed range. For every tap it loads the tap into the PHY twice through a request/acknowledge handshake. It then asks an external pattern checker for a verdict and keeps a running record of consecutive passing taps.

When the sweep ends, the engine takes the longest run of passing taps and chooses the tap halfway back from the run's last tap. It loads that tap into the PHY with the same double load and then pulses done. If no tap passed, it raises an error flag instead. If start arrives in any other speed mode, the engine answers at once and does not sweep.

Top module: `tap_tune_engine`

## Requirements
- R1: In a tuning run, taps 0 to TAP_COUNT-1 (default 40) are visited in increasing order. Every tap whose loads complete gets exactly one test request, which carries that tap on `tap_o`.
- R2: A tap load raises `tap_upd_o` with `tap_o` held steady until `tap_ack_i` is seen. Each tap is loaded twice in a row, with one low cycle of `tap_upd_o` between the loads, before `test_req_o` rises. `test_req_o` and `tap_upd_o` are never high together.
- R3: If `tap_ack_i` has not arrived after ACK_WAIT (default 16) cycles of `tap_upd_o`, the request is withdrawn. That tap counts as failing and gets no test request.
- R4: A passing verdict (`test_done_i` with `test_pass_i`=1) lengthens the current run of passing taps. A failing verdict or a load timeout ends the run.
- R5: The chosen tap is the last tap of the longest run minus half that run's length, rounded down. When two runs are equally long, the earlier one wins.
- R6: The chosen tap is loaded twice through the same handshake before `done_o` pulses, and it appears on `result_tap_o` in the cycle of that pulse.
- R7: If no tap passes, `done_o` pulses with `err_o`=1 and `result_tap_o`=0, and no final load is made.
- R8: Tuning runs only when `mode_i` is 4 (HS200-class) or 5 (SDR104-class). A start in any other mode pulses `done_o` in the next cycle, makes no load and no test, clears `err_o` and leaves `result_tap_o` unchanged.
- R9: `done_o` lasts one cycle. `result_tap_o` and `err_o` change only in a cycle where `done_o` is high. A start during a run is ignored.
- R10: If the final load times out, `done_o` pulses with `err_o`=1 and `result_tap_o` holds the chosen tap.
- R11: After reset, `done_o`, `err_o`, `result_tap_o`, `tap_o`, `tap_upd_o` and `test_req_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to start tuning |
| mode_i | input | 3 | Current bus speed mode |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run found no usable tap, or its final load timed out |
| result_tap_o | output | 6 | Tap chosen by the last run |
| tap_o | output | 6 | Tap value being loaded into the PHY |
| tap_upd_o | output | 1 | Tap load request, held until acknowledged or timed out |
| tap_ack_i | input | 1 | PHY reports that the tap load has completed |
| test_req_o | output | 1 | Request to run one tuning-block test, held until answered |
| test_done_i | input | 1 | Checker verdict is valid |
| test_pass_i | input | 1 | Verdict: 1 pass, 0 fail |

## Verification
The assertions assume that the PHY and checker act as well-behaved responders. That means a single `tap_ack_i` pulse only while `tap_upd_o` is high, and a single `test_done_i` pulse only while `test_req_o` is high, with neither held across the withdrawal of its request. The bench's responder models both. It sees a request at a falling edge and waits a short random delay. It then gives one pulse, or gives none for taps chosen to time out, and does not answer again until the request has dropped. Pass patterns come from a seeded generator, mixed with directed edge runs, ties, timeouts and a stalled final load.

// File: rtl/tune_pkg.sv
// Shared types and mode codes of the tap tuning engine.
// Assumes: the speed mode is presented as a small unsigned code.
package tune_pkg;

    // Speed mode codes that enable a tuning sweep
    localparam int MODE_HS200_CODE  = 4;
    localparam int MODE_SDR104_CODE = 5;

    // Load sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_REQ,
        SEQ_GAP
    } seq_st_e;

    // Sweep controller states
    typedef enum logic [2:0] {
        C_IDLE,
        C_COMMIT,
        C_TEST,
        C_NEXT,
        C_FINAL
    } ctl_st_e;

endpackage

// File: rtl/tap_commit_seq.sv
// Loads one tap value into the PHY twice in a row.
// Each load raises upd_o until ack_i arrives. One low cycle separates
// the two loads. A load that sees no ack within ACK_WAIT cycles is
// abandoned, and the sequence ends with fail_o.
// Assumes: go_i is only given while the sequencer is idle, and ack_i
// only arrives while upd_o is high.
module tap_commit_seq
    import tune_pkg::*;
#(
    parameter int TAP_W    = 6,
    parameter int ACK_WAIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [TAP_W-1:0] tap_i,
    input  logic             ack_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             upd_o,
    output logic             done_o,
    output logic             fail_o
);

    localparam int CNT_W = $clog2(ACK_WAIT + 1);

    seq_st_e          st;
    logic             second;
    logic [CNT_W-1:0] wait_cnt;
    logic [TAP_W-1:0] tap_q;
    logic [CNT_W-1:0] upd_run;

    // Two-round load handshake with timeout per round
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            second   <= 1'b0;
            wait_cnt <= '0;
            tap_q    <= '0;
            done_o   <= 1'b0;
            fail_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            fail_o <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (go_i) begin
                        tap_q    <= tap_i;
                        second   <= 1'b0;
                        wait_cnt <= '0;
                        st       <= SEQ_REQ;
                    end
                end
                SEQ_REQ: begin
                    if (ack_i) begin
                        wait_cnt <= '0;
                        if (second) begin
                            st     <= SEQ_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            second <= 1'b1;
                            st     <= SEQ_GAP;
                        end
                    end else if (wait_cnt == CNT_W'(ACK_WAIT - 1)) begin
                        st     <= SEQ_IDLE;
                        done_o <= 1'b1;
                        fail_o <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + CNT_W'(1);
                    end
                end
                SEQ_GAP: st <= SEQ_REQ;
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    assign upd_o = (st == SEQ_REQ);
    assign tap_o = tap_q;

    // Checker state: length of the current high stretch of upd_o
    always_ff @(posedge clk) begin
        if (!rst_n)                          upd_run <= '0;
        else if (!upd_o)                     upd_run <= '0;
        else if (upd_run < CNT_W'(ACK_WAIT)) upd_run <= upd_run + CNT_W'(1);
    end

    assert_upd_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (upd_run < CNT_W'(ACK_WAIT)));

    assert_tap_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && $past(upd_o)) |-> $stable(tap_o));

    assert_go_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (st == SEQ_IDLE));

endmodule

// File: rtl/streak_tracker.sv
// Keeps the current run length of passing taps, the longest run seen
// so far and the tap that ended it. The longest run is replaced only
// by a strictly longer one.
// Assumes: clr_i and step_i are never high together.
module streak_tracker #(
    parameter int TAP_W = 6,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             pass_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [LEN_W-1:0] cur_len_o,
    output logic [LEN_W-1:0] best_len_o,
    output logic [TAP_W-1:0] best_end_o
);

    logic [LEN_W-1:0] cur_inc;

    assign cur_inc = cur_len_o + LEN_W'(1);

    // Run bookkeeping per verdict
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cur_len_o  <= '0;
            best_len_o <= '0;
            best_end_o <= '0;
        end else if (step_i) begin
            if (pass_i) begin
                cur_len_o <= cur_inc;
                if (cur_inc > best_len_o) begin
                    best_len_o <= cur_inc;
                    best_end_o <= tap_i;
                end
            end else begin
                cur_len_o <= '0;
            end
        end
    end

    assert_cur_le_best_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_len_o <= best_len_o);

    assert_best_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (best_len_o >= $past(best_len_o)));

endmodule

// File: rtl/tune_ctrl.sv
// Sweep controller. It steps the tap index, starts the double load,
// asks for a test, reports each verdict to the run tracker, computes
// the chosen tap, loads it, and reports the outcome.
// Assumes: test_done_i only arrives while test_req_o is high, and the
// load sequencer is idle whenever this controller is idle.
module tune_ctrl
    import tune_pkg::*;
#(
    parameter int TAP_W     = 6,
    parameter int TAP_COUNT = 40,
    parameter int LEN_W     = 6,
    parameter int MODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              seq_done_i,
    input  logic              seq_fail_i,
    output logic              seq_go_o,
    output logic [TAP_W-1:0]  seq_tap_o,
    input  logic              test_done_i,
    input  logic              test_pass_i,
    output logic              test_req_o,
    output logic              trk_clr_o,
    output logic              trk_step_o,
    output logic              trk_pass_o,
    output logic [TAP_W-1:0]  trk_tap_o,
    input  logic [LEN_W-1:0]  best_len_i,
    input  logic [TAP_W-1:0]  best_end_i,
    output logic              done_o,
    output logic              err_o,
    output logic [TAP_W-1:0]  result_o
);

    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAP_COUNT - 1);

    ctl_st_e          st;
    logic [TAP_W-1:0] idx;
    logic [TAP_W-1:0] pick;
    logic [TAP_W-1:0] pick_q;
    logic             tune_mode;

    assign tune_mode = (mode_i == MODE_W'(MODE_HS200_CODE)) ||
                       (mode_i == MODE_W'(MODE_SDR104_CODE));
    assign pick      = best_end_i - TAP_W'(best_len_i >> 1);

    // Strobes toward the sequencer and the run tracker
    always_comb begin
        seq_go_o   = 1'b0;
        seq_tap_o  = idx;
        trk_clr_o  = 1'b0;
        trk_step_o = 1'b0;
        trk_pass_o = 1'b0;
        trk_tap_o  = idx;
        case (st)
            C_IDLE: begin
                if (start_i && tune_mode) begin
                    seq_go_o  = 1'b1;
                    seq_tap_o = '0;
                    trk_clr_o = 1'b1;
                end
            end
            C_COMMIT: begin
                if (seq_done_i && seq_fail_i) trk_step_o = 1'b1;
            end
            C_TEST: begin
                if (test_done_i) begin
                    trk_step_o = 1'b1;
                    trk_pass_o = test_pass_i;
                end
            end
            C_NEXT: begin
                if (idx != LAST_TAP) begin
                    seq_go_o  = 1'b1;
                    seq_tap_o = idx + TAP_W'(1);
                end else if (best_len_i != '0) begin
                    seq_go_o  = 1'b1;
                    seq_tap_o = pick;
                end
            end
            default: ;
        endcase
    end

    // Sweep state, test request and reported outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= C_IDLE;
            idx        <= '0;
            pick_q     <= '0;
            test_req_o <= 1'b0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            result_o   <= '0;
        end else begin
            done_o <= 1'b0;
            case (st)
                C_IDLE: begin
                    if (start_i) begin
                        if (tune_mode) begin
                            idx <= '0;
                            st  <= C_COMMIT;
                        end else begin
                            done_o <= 1'b1;
                            err_o  <= 1'b0;
                        end
                    end
                end
                C_COMMIT: begin
                    if (seq_done_i) begin
                        if (seq_fail_i) begin
                            st <= C_NEXT;
                        end else begin
                            test_req_o <= 1'b1;
                            st         <= C_TEST;
                        end
                    end
                end
                C_TEST: begin
                    if (test_done_i) begin
                        test_req_o <= 1'b0;
                        st         <= C_NEXT;
                    end
                end
                C_NEXT: begin
                    if (idx != LAST_TAP) begin
                        idx <= idx + TAP_W'(1);
                        st  <= C_COMMIT;
                    end else if (best_len_i == '0) begin
                        err_o    <= 1'b1;
                        result_o <= '0;
                        done_o   <= 1'b1;
                        st       <= C_IDLE;
                    end else begin
                        pick_q <= pick;
                        st     <= C_FINAL;
                    end
                end
                C_FINAL: begin
                    if (seq_done_i) begin
                        result_o <= pick_q;
                        err_o    <= seq_fail_i;
                        done_o   <= 1'b1;
                        st       <= C_IDLE;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(err_o)));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_IDLE && start_i && !tune_mode) |=> (done_o && !err_o));

    assert_test_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_req_o) |-> ($past(seq_done_i) && !$past(seq_fail_i)));

    assert_result_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (result_o < TAP_W'(TAP_COUNT)));

endmodule

// File: rtl/tap_tune_engine.sv
// Top of the sampling tap tuning engine. It joins the sweep
// controller, the two-round tap load sequencer and the passing-run
// tracker.
// Assumes: TAP_COUNT fits in TAP_W bits, and the PHY and checker obey
// the request/pulse handshakes described in the brief.
module tap_tune_engine #(
    parameter int TAP_W     = 6,
    parameter int TAP_COUNT = 40,
    parameter int ACK_WAIT  = 16,
    parameter int MODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              done_o,
    output logic              err_o,
    output logic [TAP_W-1:0]  result_tap_o,
    output logic [TAP_W-1:0]  tap_o,
    output logic              tap_upd_o,
    input  logic              tap_ack_i,
    output logic              test_req_o,
    input  logic              test_done_i,
    input  logic              test_pass_i
);

    localparam int LEN_W = $clog2(TAP_COUNT + 1);

    logic             seq_go, seq_done, seq_fail;
    logic [TAP_W-1:0] seq_tap;
    logic             trk_clr, trk_step, trk_pass;
    logic [TAP_W-1:0] trk_tap;
    logic [LEN_W-1:0] cur_len, best_len;
    logic [TAP_W-1:0] best_end;

    tune_ctrl #(
        .TAP_W(TAP_W), .TAP_COUNT(TAP_COUNT), .LEN_W(LEN_W), .MODE_W(MODE_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .seq_done_i(seq_done), .seq_fail_i(seq_fail),
        .seq_go_o(seq_go), .seq_tap_o(seq_tap),
        .test_done_i(test_done_i), .test_pass_i(test_pass_i),
        .test_req_o(test_req_o),
        .trk_clr_o(trk_clr), .trk_step_o(trk_step), .trk_pass_o(trk_pass),
        .trk_tap_o(trk_tap),
        .best_len_i(best_len), .best_end_i(best_end),
        .done_o(done_o), .err_o(err_o), .result_o(result_tap_o)
    );

    tap_commit_seq #(
        .TAP_W(TAP_W), .ACK_WAIT(ACK_WAIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .go_i(seq_go), .tap_i(seq_tap),
        .ack_i(tap_ack_i), .tap_o(tap_o), .upd_o(tap_upd_o),
        .done_o(seq_done), .fail_o(seq_fail)
    );

    streak_tracker #(
        .TAP_W(TAP_W), .LEN_W(LEN_W)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .clr_i(trk_clr), .step_i(trk_step),
        .pass_i(trk_pass), .tap_i(trk_tap),
        .cur_len_o(cur_len), .best_len_o(best_len), .best_end_o(best_end)
    );

    assert_req_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_req_o && tap_upd_o));

endmodule

// File: tb/tb_tap_tune_engine.sv
// Self-checking bench: a seeded random responder for the PHY and the
// checker, plus directed sweeps, compared against a bench model.
module tb_tap_tune_engine;

    localparam int CLK_P  = 10;
    localparam int NTAP   = 40;
    localparam int WDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [2:0] mode;
    logic       done, err, tap_upd, tap_ack, test_req, test_done, test_pass;
    logic [5:0] result_tap, tap_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [NTAP-1:0] pass_m, stall_m;
    bit              stall_fin;
    int              commits, last_ctap, tests, last_ttap, exp_tests;
    int              adly, tdly;
    bit              agiven, tgiven, tseen;

    always #(CLK_P/2) clk = ~clk;

    tap_tune_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .done_o(done), .err_o(err), .result_tap_o(result_tap),
        .tap_o(tap_out), .tap_upd_o(tap_upd), .tap_ack_i(tap_ack),
        .test_req_o(test_req), .test_done_i(test_done), .test_pass_i(test_pass)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: longest passing run, earliest on tie
    function automatic void model(input logic [NTAP-1:0] ok, output bit e, output int r);
        int cur, best, fin;
        cur = 0; best = 0; fin = 0;
        for (int i = 0; i < NTAP; i++) begin
            if (ok[i]) begin
                cur++;
                if (cur > best) begin best = cur; fin = i; end
            end else cur = 0;
        end
        e = (best == 0);
        r = e ? 0 : fin - best / 2;
    endfunction

    // PHY and checker responder, acting at falling edges
    initial begin
        tap_ack = 0; test_done = 0; test_pass = 0;
        agiven = 0; tgiven = 0; tseen = 0; adly = 0; tdly = 0;
        forever begin
            @(negedge clk);
            tap_ack = 0;
            test_done = 0;
            if (rst_n !== 1'b1) begin
                agiven = 0; tgiven = 0; tseen = 0;
            end else begin
                if (tap_upd && !agiven) begin
                    if (adly > 0) adly--;
                    else if (!(stall_m[tap_out] || (stall_fin && tests == exp_tests))) begin
                        tap_ack = 1;
                        agiven = 1;
                        if (int'(tap_out) != last_ctap) commits = 0;
                        commits++;
                        last_ctap = int'(tap_out);
                    end
                end
                if (!tap_upd) begin agiven = 0; adly = $urandom % 3; end
                if (test_req && !tgiven) begin
                    if (!tseen) begin
                        tseen = 1;
                        chk(commits == 2 && last_ctap == int'(tap_out), "R2", commits, 2);
                        chk(int'(tap_out) > last_ttap && !stall_m[tap_out], "R1/R3",
                            int'(tap_out), last_ttap + 1);
                        tests++;
                        last_ttap = int'(tap_out);
                        commits = 0;
                    end
                    if (tdly > 0) tdly--;
                    else begin
                        test_done = 1;
                        test_pass = pass_m[tap_out];
                        tgiven = 1;
                    end
                end
                if (!test_req) begin tgiven = 0; tseen = 0; tdly = $urandom % 4; end
            end
        end
    end

    task automatic run(input logic [2:0] md, input logic [NTAP-1:0] pm,
                       input logic [NTAP-1:0] sm, input bit sf, input bit poke,
                       input string tag);
        bit e_err; int e_res; int cyc; logic [5:0] prev_res; bit tune;
        pass_m = pm; stall_m = sm; stall_fin = sf;
        tests = 0; last_ttap = -1; commits = 0; last_ctap = -1;
        exp_tests = NTAP - $countones(sm);
        prev_res = result_tap;
        tune = (md == 3'd4) || (md == 3'd5);
        model(pm & ~sm, e_err, e_res);
        @(negedge clk); start = 1; mode = md;
        @(negedge clk); start = 0;
        if (!tune) begin
            chk(done == 1'b1, "R8", int'(done), 1);
            chk(err == 1'b0, "R8", int'(err), 0);
            chk(result_tap == prev_res, "R8", int'(result_tap), int'(prev_res));
            @(negedge clk);
            chk(done == 1'b0, "R9", int'(done), 0);
            chk(tests == 0 && commits == 0 && !tap_upd, "R8", tests + commits, 0);
        end else begin
            cyc = 0;
            while (!done && cyc < 20000) begin
                @(negedge clk);
                cyc++;
                if (poke && cyc == 50) begin start = 1; mode = 3'd0; end
                else start = 0;
            end
            chk(done == 1'b1, {tag, " completion"}, int'(done), 1);
            chk(tests == exp_tests, "R1/R3", tests, exp_tests);
            if (sf && !e_err) begin
                chk(err == 1'b1, "R10", int'(err), 1);
                chk(int'(result_tap) == e_res, "R10", int'(result_tap), e_res);
            end else begin
                chk(err == e_err, {tag, " err"}, int'(err), int'(e_err));
                chk(int'(result_tap) == e_res, tag, int'(result_tap), e_res);
                if (e_err) chk(commits == 0, "R7", commits, 0);
                else chk(commits == 2 && last_ctap == e_res, "R6", last_ctap, e_res);
            end
            prev_res = result_tap;
            @(negedge clk);
            chk(done == 1'b0, "R9", int'(done), 0);
            chk(result_tap == prev_res, "R9", int'(result_tap), int'(prev_res));
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * WDOG);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NTAP-1:0] pm, sm;
        void'($urandom(32'd2024));
        pass_m = '0; stall_m = '0; stall_fin = 0;
        commits = 0; last_ctap = -1; tests = 0; last_ttap = -1; exp_tests = NTAP;
        rst_n = 0; start = 0; mode = 3'd0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!done && !err, "R11", int'(done) + int'(err), 0);
        chk(result_tap == 6'd0 && tap_out == 6'd0, "R11", int'(result_tap), 0);
        chk(!tap_upd && !test_req, "R11", int'(tap_upd) + int'(test_req), 0);

        run(3'd4, {NTAP{1'b1}}, '0, 0, 0, "R5 all pass");
        run(3'd0, '0, '0, 0, 0, "R8");
        run(3'd5, '0, '0, 0, 0, "R7 none pass");
        run(3'd3, '0, '0, 0, 0, "R8");
        run(3'd4, 40'h1, '0, 0, 0, "R5 first only");
        run(3'd5, 40'h80_0000_0000, '0, 0, 0, "R5 last only");
        run(3'd4, 40'h1F003E0, '0, 0, 0, "R5 tie");
        run(3'd4, 40'hFF_F0FF_FF0F, '0, 0, 0, "R4 split");
        run(3'd5, {NTAP{1'b1}}, 40'h400, 0, 0, "R3 timeout");
        run(3'd4, {NTAP{1'b1}}, '0, 1, 0, "R10");
        run(3'd4, 40'h0F_FFF0_0FF0, '0, 0, 1, "R9 busy start");
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < NTAP; i++) begin
                pm[i] = ($urandom % 5) != 0;
                sm[i] = ($urandom % 16) == 0;
            end
            run(3'd4 + 3'($urandom % 2), pm, sm, 0, 0, "R4/R5 random");
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule